// File: doc/BRIEF.md
# LCD Panel Power and Display Sequencer

This block brings a TFT panel controller up and down in the order its analog supplies need. It turns on/off/sleep commands into an ordered run of register writes. Each write is a register index and a 16-bit value, handed to an external register write master over a valid/ready pair. Between certain writes it holds for a programmed number of clock ticks. These holds cover oscillator start, booster settling, and the frame gaps the gate and source drivers need.

A display-on command from the unpowered state first runs the full power-up program, then the display enable ramp. A sleep command takes the display down if it is lit, then removes power if power is present, and always ends with the standby write. The contrast setting is clamped and merged into the booster register. The invert flag selects the polarity term merged into every display-control write. Both are captured when a command is accepted and held for the whole run.

Top module: `lcd_pwr_seq`

## Requirements
- R1: Power-up issues, in order: reg 0x03 ← 0x0000, reg 0x00 ← 0x0001, a hold of T_OSC_TICKS, reg 0x0C ← 0x0001, reg 0x0D ← 0x0401, reg 0x04 ← 0x8000, reg 0x0E ← 0x0018|C, reg 0x03 ← 0x002C, reg 0x0E ← 0x2018|C, a hold of T_STEP_TICKS, reg 0x0D ← 0x0411, a hold of T_STEP_TICKS, then the mode table. The mode table is 01←0313, 02←0700, 05←1038, 06←0000, 0B←4000, 0F←0002, 16←7F00, 30←0003, 31←0400, 3A←1409, 3B←0602. A hold of T_SETTLE_TICKS follows the table.
- R2: Display-on writes reg 0x07 with 0x0001, holds T_FRAME_TICKS, writes 0x0021|V and 0x0023|V, holds T_FRAME_TICKS, then writes 0x0033|V; display_on rises when the run ends.
- R3: Display-off writes reg 0x07 with 0x0032|V, holds, writes 0x0022|V, holds, then writes 0x0000; display_on falls as the run starts.
- R4: Sleep runs display-off if the display is lit. It then runs power-down if power is present: reg 0x03 ← 0x062C, reg 0x0D ← 0x0401, reg 0x0E ← 0x0018|C, a hold of T_SETTLE_TICKS, reg 0x03 ← 0x0000. It always ends with reg 0x03 ← 0x0001.
- R5: C is the signed contrast input clamped to 0..30 and placed at bits 12:8. Inputs ≤0 give 0, inputs 1..15 give input−1, inputs 16..30 pass unchanged, and inputs >30 give 30.
- R6: V is 0x0004 when invert is low and 0x0000 when invert is high.
- R7: Display-on while power_on is low runs power-up first; power_on rises at the end of power-up, before the enable ramp starts.
- R8: Display-on while lit, and display-off while dark, produce no writes and no flag change. Commands that arrive while busy is high are dropped.
- R9: After each hold of N ticks, the next write is accepted more than N cycles after the write that came before the hold.
- R10: While wr_valid is high and wr_ready is low, wr_valid, wr_reg and wr_data keep their values.
- R11: When several commands arrive in one idle cycle, sleep wins over off, and off wins over on.
- R12: Reset clears power_on, display_on, busy and wr_valid. power_on changes only at the end of a power run. display_on never stands high while power_on is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Display-on command pulse |
| req_off | input | 1 | Display-off command pulse |
| req_sleep | input | 1 | Sleep/standby command pulse |
| contrast | input | CON_W | Signed contrast setting |
| invert | input | 1 | Inverted display polarity |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write master accepts the request |
| wr_reg | output | 8 | Register index |
| wr_data | output | 16 | Register value |
| busy | output | 1 | A sequence is running |
| power_on | output | 1 | Panel supplies are up |
| display_on | output | 1 | Panel display is enabled |

## Verification
The command table is run in several ways, and each run shows a different behaviour. A cold display-on exercises the chained power-up and enable ramp. A display-on with power already up shows that power-up is skipped. A sleep from the lit state separates the three-stage teardown from the bare standby write that a sleep from the dark state produces. Repeated commands that match the current state must produce an empty write log. Contrast values of −3, 1, 15, 16, 31 and 40 sit on each clamp boundary, and both invert settings show up in the display-control values. Some runs stall the ready line at random, to show that writes hold steady under back-pressure and that hold gaps stay long enough. Directed cases cover commands during a run, simultaneous commands, and a reset in the middle of power-up.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PWRUP,
    PH_DISPON,
    PH_DISPOFF,
    PH_PWRDN,
    PH_STANDBY
  } phase_e;

  typedef enum logic [1:0] {
    OP_WRITE,
    OP_WAIT,
    OP_DONE
  } op_e;

  typedef enum logic [1:0] {
    MG_NONE,
    MG_CONTRAST,
    MG_POLARITY
  } merge_e;

  typedef enum logic [1:0] {
    WT_OSC,
    WT_STEP,
    WT_SETTLE,
    WT_FRAME
  } wsel_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  regidx;
    logic [15:0] base;
    merge_e      mg;
    wsel_e       ws;
  } step_t;

  localparam int STEP_IDX_W = 5;
  localparam int LEVEL_W    = 5;

  function automatic step_t st_wr(logic [7:0] r, logic [15:0] v, merge_e m);
    step_t s;
    s.op     = OP_WRITE;
    s.regidx = r;
    s.base   = v;
    s.mg     = m;
    s.ws     = WT_OSC;
    return s;
  endfunction

  function automatic step_t st_wait(wsel_e w);
    step_t s;
    s.op     = OP_WAIT;
    s.regidx = 8'h00;
    s.base   = 16'h0000;
    s.mg     = MG_NONE;
    s.ws     = w;
    return s;
  endfunction

  function automatic step_t st_done();
    step_t s;
    s.op     = OP_DONE;
    s.regidx = 8'h00;
    s.base   = 16'h0000;
    s.mg     = MG_NONE;
    s.ws     = WT_OSC;
    return s;
  endfunction

endpackage

// File: rtl/lcd_contrast_clamp.sv
module lcd_contrast_clamp
  import lcd_seq_pkg::*;
#(
  parameter int CON_W = 8
) (
  input  logic signed [CON_W-1:0] raw,
  output logic [LEVEL_W-1:0]      level
);

  int v;

  always_comb begin
    v = int'(raw);
    if (v < 1) begin
      level = '0;
    end else if (v <= 15) begin
      level = LEVEL_W'(v - 1);
    end else if (v > 30) begin
      level = LEVEL_W'(30);
    end else begin
      level = LEVEL_W'(v);
    end
  end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run && (cnt_q == (limit - TW'(1)));
    cnt_d  = (run && !done) ? cnt_q + TW'(1) : '0;
    cnt_en = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lcd_step_rom.sv
module lcd_step_rom
  import lcd_seq_pkg::*;
(
  input  phase_e                phase,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_t                 step
);

  always_comb begin
    step = st_done();
    unique case (phase)
      PH_PWRUP: begin
        case (idx)
          5'd0:  step = st_wr(8'h03, 16'h0000, MG_NONE);
          5'd1:  step = st_wr(8'h00, 16'h0001, MG_NONE);
          5'd2:  step = st_wait(WT_OSC);
          5'd3:  step = st_wr(8'h0C, 16'h0001, MG_NONE);
          5'd4:  step = st_wr(8'h0D, 16'h0401, MG_NONE);
          5'd5:  step = st_wr(8'h04, 16'h8000, MG_NONE);
          5'd6:  step = st_wr(8'h0E, 16'h0018, MG_CONTRAST);
          5'd7:  step = st_wr(8'h03, 16'h002C, MG_NONE);
          5'd8:  step = st_wr(8'h0E, 16'h2018, MG_CONTRAST);
          5'd9:  step = st_wait(WT_STEP);
          5'd10: step = st_wr(8'h0D, 16'h0411, MG_NONE);
          5'd11: step = st_wait(WT_STEP);
          5'd12: step = st_wr(8'h01, 16'h0313, MG_NONE);
          5'd13: step = st_wr(8'h02, 16'h0700, MG_NONE);
          5'd14: step = st_wr(8'h05, 16'h1038, MG_NONE);
          5'd15: step = st_wr(8'h06, 16'h0000, MG_NONE);
          5'd16: step = st_wr(8'h0B, 16'h4000, MG_NONE);
          5'd17: step = st_wr(8'h0F, 16'h0002, MG_NONE);
          5'd18: step = st_wr(8'h16, 16'h7F00, MG_NONE);
          5'd19: step = st_wr(8'h30, 16'h0003, MG_NONE);
          5'd20: step = st_wr(8'h31, 16'h0400, MG_NONE);
          5'd21: step = st_wr(8'h3A, 16'h1409, MG_NONE);
          5'd22: step = st_wr(8'h3B, 16'h0602, MG_NONE);
          5'd23: step = st_wait(WT_SETTLE);
          default: step = st_done();
        endcase
      end
      PH_DISPON: begin
        case (idx)
          5'd0: step = st_wr(8'h07, 16'h0001, MG_NONE);
          5'd1: step = st_wait(WT_FRAME);
          5'd2: step = st_wr(8'h07, 16'h0021, MG_POLARITY);
          5'd3: step = st_wr(8'h07, 16'h0023, MG_POLARITY);
          5'd4: step = st_wait(WT_FRAME);
          5'd5: step = st_wr(8'h07, 16'h0033, MG_POLARITY);
          default: step = st_done();
        endcase
      end
      PH_DISPOFF: begin
        case (idx)
          5'd0: step = st_wr(8'h07, 16'h0032, MG_POLARITY);
          5'd1: step = st_wait(WT_FRAME);
          5'd2: step = st_wr(8'h07, 16'h0022, MG_POLARITY);
          5'd3: step = st_wait(WT_FRAME);
          5'd4: step = st_wr(8'h07, 16'h0000, MG_NONE);
          default: step = st_done();
        endcase
      end
      PH_PWRDN: begin
        case (idx)
          5'd0: step = st_wr(8'h03, 16'h062C, MG_NONE);
          5'd1: step = st_wr(8'h0D, 16'h0401, MG_NONE);
          5'd2: step = st_wr(8'h0E, 16'h0018, MG_CONTRAST);
          5'd3: step = st_wait(WT_SETTLE);
          5'd4: step = st_wr(8'h03, 16'h0000, MG_NONE);
          default: step = st_done();
        endcase
      end
      PH_STANDBY: begin
        case (idx)
          5'd0: step = st_wr(8'h03, 16'h0001, MG_NONE);
          default: step = st_done();
        endcase
      end
      default: step = st_done();
    endcase
  end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_seq_pkg::*;
#(
  parameter int CON_W          = 8,
  parameter int T_OSC_TICKS    = 500000,
  parameter int T_STEP_TICKS   = 2000000,
  parameter int T_SETTLE_TICKS = 5000000,
  parameter int T_FRAME_TICKS  = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_on,
  input  logic             req_off,
  input  logic             req_sleep,
  input  logic [CON_W-1:0] contrast,
  input  logic             invert,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [7:0]       wr_reg,
  output logic [15:0]      wr_data,
  output logic             busy,
  output logic             power_on,
  output logic             display_on
);

  localparam int T_MAX_A = (T_OSC_TICKS > T_STEP_TICKS) ? T_OSC_TICKS : T_STEP_TICKS;
  localparam int T_MAX_B = (T_SETTLE_TICKS > T_FRAME_TICKS) ? T_SETTLE_TICKS : T_FRAME_TICKS;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int TW      = $clog2(T_MAX + 1);

  phase_e                phase_q, phase_d;
  logic [STEP_IDX_W-1:0] idx_q, idx_d;
  logic                  chain_q, chain_d;
  logic [LEVEL_W-1:0]    lvl_q;
  logic                  inv_q;
  logic                  pwr_q, pwr_d;
  logic                  disp_q, disp_d;
  logic                  cap_en;
  logic                  seq_en;

  logic [LEVEL_W-1:0]    lvl_now;
  step_t                 step;
  logic                  wait_run, wait_done;
  logic [TW-1:0]         wait_limit;
  logic [15:0]           merge_val;

  lcd_contrast_clamp #(.CON_W(CON_W)) i_clamp (
    .raw   ($signed(contrast)),
    .level (lvl_now)
  );

  lcd_step_rom i_rom (
    .phase (phase_q),
    .idx   (idx_q),
    .step  (step)
  );

  lcd_wait_timer #(.TW(TW)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (wait_run),
    .limit (wait_limit),
    .done  (wait_done)
  );

  always_comb begin
    wait_run = (phase_q != PH_IDLE) && (step.op == OP_WAIT);
    unique case (step.ws)
      WT_OSC:    wait_limit = TW'(T_OSC_TICKS);
      WT_STEP:   wait_limit = TW'(T_STEP_TICKS);
      WT_SETTLE: wait_limit = TW'(T_SETTLE_TICKS);
      default:   wait_limit = TW'(T_FRAME_TICKS);
    endcase
  end

  always_comb begin
    unique case (step.mg)
      MG_CONTRAST: merge_val = {3'b000, lvl_q, 8'h00};
      MG_POLARITY: merge_val = inv_q ? 16'h0000 : 16'h0004;
      default:     merge_val = 16'h0000;
    endcase
    busy     = (phase_q != PH_IDLE);
    wr_valid = busy && (step.op == OP_WRITE);
    wr_reg   = step.regidx;
    wr_data  = step.base | merge_val;
    power_on   = pwr_q;
    display_on = disp_q;
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    chain_d = chain_q;
    pwr_d   = pwr_q;
    disp_d  = disp_q;
    cap_en  = 1'b0;
    if (phase_q == PH_IDLE) begin
      idx_d = '0;
      if (req_sleep) begin
        cap_en  = 1'b1;
        chain_d = 1'b1;
        if (disp_q) begin
          phase_d = PH_DISPOFF;
          disp_d  = 1'b0;
        end else if (pwr_q) begin
          phase_d = PH_PWRDN;
        end else begin
          phase_d = PH_STANDBY;
        end
      end else if (req_off && disp_q) begin
        cap_en  = 1'b1;
        chain_d = 1'b0;
        phase_d = PH_DISPOFF;
        disp_d  = 1'b0;
      end else if (req_on && !disp_q) begin
        cap_en  = 1'b1;
        chain_d = 1'b0;
        phase_d = pwr_q ? PH_DISPON : PH_PWRUP;
      end
    end else begin
      unique case (step.op)
        OP_WRITE: if (wr_ready)  idx_d = STEP_IDX_W'(idx_q + 1'b1);
        OP_WAIT:  if (wait_done) idx_d = STEP_IDX_W'(idx_q + 1'b1);
        default: begin
          idx_d = '0;
          unique case (phase_q)
            PH_PWRUP: begin
              pwr_d   = 1'b1;
              phase_d = PH_DISPON;
            end
            PH_DISPON: begin
              disp_d  = 1'b1;
              phase_d = PH_IDLE;
            end
            PH_DISPOFF: phase_d = (chain_q && pwr_q) ? PH_PWRDN :
                                  (chain_q ? PH_STANDBY : PH_IDLE);
            PH_PWRDN: begin
              pwr_d   = 1'b0;
              phase_d = PH_STANDBY;
            end
            default: phase_d = PH_IDLE;
          endcase
        end
      endcase
    end
    seq_en = (phase_d != phase_q) || (idx_d != idx_q) ||
             (pwr_d != pwr_q) || (disp_d != disp_q) || (chain_d != chain_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      chain_q <= 1'b0;
      pwr_q   <= 1'b0;
      disp_q  <= 1'b0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      chain_q <= chain_d;
      pwr_q   <= pwr_d;
      disp_q  <= disp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      inv_q <= 1'b0;
    end else if (cap_en) begin
      lvl_q <= lvl_now;
      inv_q <= invert;
    end
  end

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [7:0]  wr_reg,
  input logic [15:0] wr_data,
  input logic        busy,
  input logic        power_on,
  input logic        display_on
);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_reg) && $stable(wr_data)));

  a_r12_disp_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    display_on |-> power_on);

  a_r12_power_rise_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_on) |-> $past(busy));

  a_r2_ctrl_only_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_reg == 8'h07) |-> power_on);

  a_r3_blank_when_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_reg == 8'h07 && wr_data == 16'h0000) |-> !display_on);

  a_r4_standby_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_reg == 8'h03 && wr_data == 16'h0001) |-> (!power_on && !display_on));

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_reg     (wr_reg),
  .wr_data    (wr_data),
  .busy       (busy),
  .power_on   (power_on),
  .display_on (display_on)
);

// File: tb/test_lcd_pwr_seq.sv
module test_lcd_pwr_seq;

  localparam int TO  = 5;
  localparam int TS  = 7;
  localparam int TST = 11;
  localparam int TF  = 3;
  localparam int NV  = 12;

  // vector: {on, off, sleep, stall, invert, exp_pwr, exp_disp, contrast[7:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd10},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd10},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd10},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd10},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFD},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd40},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd16},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd15},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd31}
  };

  string vtag [NV] = '{"R7", "R8", "R3", "R8", "R6", "R4",
                       "R4", "R8", "R5", "R5", "R1", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_on = 1'b0, req_off = 1'b0, req_sleep = 1'b0;
  logic [7:0]  con = 8'd0;
  logic        inv = 1'b0;
  logic        rdy = 1'b1;
  logic        wr_valid, busy, power_on, display_on;
  logic [7:0]  wr_reg;
  logic [15:0] wr_data;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0]  rec_reg [64];
  logic [15:0] rec_dat [64];
  int          rec_cyc [64];
  int          rec_n = 0;
  logic [7:0]  exp_reg [64];
  logic [15:0] exp_dat [64];
  int          exp_gap [64];
  int          exp_n = 0, pend_gap = 0;
  bit          m_pwr = 0, m_disp = 0, stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  lcd_pwr_seq #(
    .CON_W(8), .T_OSC_TICKS(TO), .T_STEP_TICKS(TS),
    .T_SETTLE_TICKS(TST), .T_FRAME_TICKS(TF)
  ) i_lcd_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .req_sleep(req_sleep), .contrast(con), .invert(inv),
    .wr_valid(wr_valid), .wr_ready(rdy), .wr_reg(wr_reg), .wr_data(wr_data),
    .busy(busy), .power_on(power_on), .display_on(display_on)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy  = !stall_en || lfsr[0];
    if (rst_n && wr_valid && rdy && rec_n < 64) begin
      rec_reg[rec_n] = wr_reg;
      rec_dat[rec_n] = wr_data;
      rec_cyc[rec_n] = cyc;
      rec_n++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int clamp_ref(int v);
    if (v <= 0) return 0;
    if (v < 16) return v - 1;
    if (v <= 30) return v;
    return 30;
  endfunction

  task automatic push(logic [7:0] r, logic [15:0] d);
    exp_reg[exp_n] = r;
    exp_dat[exp_n] = d;
    exp_gap[exp_n] = pend_gap;
    pend_gap = 0;
    exp_n++;
  endtask

  task automatic model_pu(logic [15:0] cc);
    push(8'h03, 16'h0000); push(8'h00, 16'h0001); pend_gap = TO;
    push(8'h0C, 16'h0001); push(8'h0D, 16'h0401); push(8'h04, 16'h8000);
    push(8'h0E, 16'h0018 | cc); push(8'h03, 16'h002C); push(8'h0E, 16'h2018 | cc);
    pend_gap = TS; push(8'h0D, 16'h0411); pend_gap = TS;
    push(8'h01, 16'h0313); push(8'h02, 16'h0700); push(8'h05, 16'h1038);
    push(8'h06, 16'h0000); push(8'h0B, 16'h4000); push(8'h0F, 16'h0002);
    push(8'h16, 16'h7F00); push(8'h30, 16'h0003); push(8'h31, 16'h0400);
    push(8'h3A, 16'h1409); push(8'h3B, 16'h0602); pend_gap = TST;
  endtask

  task automatic model_don(logic [15:0] rv);
    push(8'h07, 16'h0001); pend_gap = TF;
    push(8'h07, 16'h0021 | rv); push(8'h07, 16'h0023 | rv); pend_gap = TF;
    push(8'h07, 16'h0033 | rv);
  endtask

  task automatic model_doff(logic [15:0] rv);
    push(8'h07, 16'h0032 | rv); pend_gap = TF;
    push(8'h07, 16'h0022 | rv); pend_gap = TF;
    push(8'h07, 16'h0000);
  endtask

  task automatic model_pd(logic [15:0] cc);
    push(8'h03, 16'h062C); push(8'h0D, 16'h0401); push(8'h0E, 16'h0018 | cc);
    pend_gap = TST; push(8'h03, 16'h0000);
  endtask

  task automatic model_cmd(bit on, bit off, bit slp, logic [7:0] c, bit iv);
    logic [15:0] rv, cc;
    rv = iv ? 16'h0000 : 16'h0004;
    cc = 16'(clamp_ref(int'($signed(c)))) << 8;
    exp_n = 0; pend_gap = 0; rec_n = 0;
    if (slp) begin
      if (m_disp) begin model_doff(rv); m_disp = 0; end
      if (m_pwr) begin model_pd(cc); m_pwr = 0; end
      push(8'h03, 16'h0001);
    end else if (off && m_disp) begin
      model_doff(rv); m_disp = 0;
    end else if (on && !m_disp) begin
      if (!m_pwr) begin model_pu(cc); m_pwr = 1; end
      model_don(rv); m_disp = 1;
    end
  endtask

  task automatic pulse(bit on, bit off, bit slp, logic [7:0] c, bit iv);
    @(negedge clk);
    req_on = on; req_off = off; req_sleep = slp; con = c; inv = iv;
    @(negedge clk);
    req_on = 0; req_off = 0; req_sleep = 0;
  endtask

  task automatic finish_and_compare(string tag);
    while (busy) @(negedge clk);
    check(rec_n == exp_n, tag, "write count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      check(rec_reg[i] == exp_reg[i], tag, $sformatf("reg of write %0d", i),
            rec_reg[i], exp_reg[i]);
      check(rec_dat[i] == exp_dat[i], tag, $sformatf("data of write %0d", i),
            rec_dat[i], exp_dat[i]);
      if (i > 0 && exp_gap[i] > 0)
        check(rec_cyc[i] - rec_cyc[i-1] > exp_gap[i], "R9",
              $sformatf("hold before write %0d", i),
              rec_cyc[i] - rec_cyc[i-1], exp_gap[i] + 1);
    end
    check(power_on == m_pwr, "R12", "power_on", power_on, m_pwr);
    check(display_on == m_disp, "R12", "display_on", display_on, m_disp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!power_on && !display_on, "R12", "flags in reset", {power_on, display_on}, 0);
    check(!busy && !wr_valid, "R12", "idle in reset", {busy, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wr_valid, "R12", "idle after reset", {busy, wr_valid}, 0);

    // table walk (R1..R10 by vector tag, R10 under stalled ready)
    for (int v = 0; v < NV; v++) begin
      stall_en = VEC[v][11];
      model_cmd(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][7:0], VEC[v][10]);
      pulse(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][7:0], VEC[v][10]);
      finish_and_compare(vtag[v]);
      check(power_on == VEC[v][9] && display_on == VEC[v][8], vtag[v],
            "table flags", {power_on, display_on}, VEC[v][9:8]);
    end
    stall_en = 0;

    // R8: commands during a run are dropped
    model_cmd(1, 0, 0, 8'd5, 0);
    pulse(1, 0, 0, 8'd5, 0);
    repeat (4) @(negedge clk);
    req_sleep = 1; @(negedge clk); req_sleep = 0;
    finish_and_compare("R8");

    // R11: all three at once, sleep wins
    model_cmd(1, 1, 1, 8'd22, 0);
    pulse(1, 1, 1, 8'd22, 0);
    finish_and_compare("R11");
    // R11: on+off from dark, on acts (off matches state)
    model_cmd(1, 1, 0, 8'd22, 1);
    pulse(1, 1, 0, 8'd22, 1);
    finish_and_compare("R11");
    // R11: on+off while lit, off wins
    model_cmd(1, 1, 0, 8'd22, 0);
    pulse(1, 1, 0, 8'd22, 0);
    finish_and_compare("R11");

    // R12: reset in the middle of power-up
    model_cmd(0, 0, 1, 8'd0, 0);
    pulse(0, 0, 1, 8'd0, 0);
    finish_and_compare("R4");
    pulse(1, 0, 0, 8'd7, 0);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!power_on && !display_on, "R12", "flags after mid-run reset",
          {power_on, display_on}, 0);
    check(!busy && !wr_valid, "R12", "idle after mid-run reset", {busy, wr_valid}, 0);
    rst_n = 1'b1;
    m_pwr = 0; m_disp = 0;
    model_cmd(1, 0, 0, 8'd7, 0);
    pulse(1, 0, 0, 8'd7, 0);
    finish_and_compare("R7");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule